// File: doc/BRIEF.md
# NAND Flash Command and Address Front End

This block sits at the pin side of a small-page, byte-wide NAND flash device model. Every write strobe on the 8-bit input bus is classified by the command-latch, address-latch and active-low chip-select pins as a command, an address byte or a data byte. Commands are decoded into an operation, address bytes are packed into an address register, and at the right address-cycle count the block fires one-cycle start pulses (page read, program window open, program commit, block erase) to a separate array block. The column, row and preset read offset travel alongside those pulses.

Besides the array traffic, the block answers two sequences on its own: the identification read, which returns a fixed four-byte signature, and the status read, whose byte is captured when the command arrives and then repeats on every read until another command replaces it. Two alternate read opcodes reuse the plain page read and only preset the starting column, either to the middle of the main area or to the start of the spare area. Write protection gates the commit steps of program and erase, and its pin level shows in the top status bit.

Top module: `nand_front_end`

## Requirements
- R1: A command byte is taken only on a write strobe with `chip_sel_n` low and `cmd_lat` high; address bytes need `adr_lat` high and `cmd_lat` low, data bytes need both latches low, all with `chip_sel_n` low. Strobes with `chip_sel_n` high have no effect.
- R2: Recognised opcodes are 0x00, 0x01, 0x50 (page read), 0x90 (identify), 0xFF (reset), 0x80/0x10 (program setup/commit), 0x60/0xD0 (erase setup/commit) and 0x70 (status). Any other opcode raises `bad_cmd` for one cycle and leaves every piece of state, including the address byte count, unchanged.
- R3: 0x00 sets the read offset to 0, 0x01 to half a page (0x100), 0x50 to one page (0x200); the offset is added to the column byte and is cleared once a read or program window starts.
- R4: Address byte n (counting from 0 since the last recognised command) is stored at bits 8n+7..8n; a recognised command clears the count; bytes beyond the third are ignored.
- R5: In page-read mode the third address byte raises `rd_start` for one cycle after the strobe, with `op_col` = column byte + offset and `op_row` = {byte 2, byte 1}; then `io_out` shows `arr_rdata` and each read strobe pulses `arr_next`, for 528 − `op_col` reads (none if `op_col` ≥ 528).
- R6: The first address byte after 0x90 starts the identify response: 0x3A, 0x73, 0xA5, 0xC0, one byte per read strobe, then zero.
- R7: The status byte has bit 7 = write-protect pin level (registered), bit 6 = ready (always 1) and all other bits 0; it is captured at the 0x70 strobe and every read returns it without advancing until the next command.
- R8: In program mode the third address byte raises `pgm_open` with `op_col`/`op_row` as in R5; each data byte raises `pgm_data_we` in the strobe cycle for the first 528 bytes only; 0x10 raises `pgm_commit` one cycle later only when `wr_prot_n` is high.
- R9: 0xD0 keeps only the address bytes received since 0x60 (others zeroed), shifts them up one byte, and raises `ers_start` with `op_row` = those bytes, only when `wr_prot_n` is high.
- R10: Command 0xFF returns to page-read mode with zero offset, zero address, zero count and no pending output data; status shows ready.
- R11: `io_out` is zero while `chip_sel_n` is high or no response data is left; read strobes with `chip_sel_n` high do not advance; every recognised command other than 0x70 discards pending response data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_sel_n | input | 1 | Device select, active low |
| cmd_lat | input | 1 | Marks the strobed byte as a command |
| adr_lat | input | 1 | Marks the strobed byte as an address byte |
| wr_prot_n | input | 1 | Write protect, active low |
| wr_stb | input | 1 | Write strobe, one cycle per byte |
| rd_stb | input | 1 | Read strobe, advances the output byte |
| io_in | input | 8 | Input bus byte |
| io_out | output | 8 | Output bus byte |
| arr_rdata | input | 8 | Current read byte from the array block |
| arr_next | output | 1 | Array read byte consumed |
| rd_start | output | 1 | Page read start pulse |
| pgm_open | output | 1 | Program window start pulse |
| pgm_data_we | output | 1 | Program data byte valid on `io_in` |
| pgm_commit | output | 1 | Program commit pulse |
| ers_start | output | 1 | Block erase pulse |
| op_col | output | 10 | Start column of the last read or program |
| op_row | output | 16 | Row of the last read, program or erase |
| bad_cmd | output | 1 | Unrecognised opcode pulse |

## Verification
The start pulses, `bad_cmd`, `op_col`, `op_row` and the response selection are registered at the strobe edge, so each is due one cycle after the strobe; the bench drives a strobe on a falling edge, lets exactly one rising edge take it, and checks these results on the next falling edge, before the following rising edge clears the pulses. `pgm_data_w` and `arr_next` are combinational from the strobe and are sampled shortly after the strobe is driven, while `io_out` is checked before each read strobe. The status bit 7 lags the pin by one register, so the bench waits two cycles after moving `wr_prot_n` before issuing 0x70.

// File: rtl/nand_fe_pkg.sv
package nand_fe_pkg;

  localparam logic [7:0] OPC_RD_MAIN  = 8'h00;
  localparam logic [7:0] OPC_RD_HALF  = 8'h01;
  localparam logic [7:0] OPC_RD_SPARE = 8'h50;
  localparam logic [7:0] OPC_IDENT    = 8'h90;
  localparam logic [7:0] OPC_RESET    = 8'hFF;
  localparam logic [7:0] OPC_PGM_SET  = 8'h80;
  localparam logic [7:0] OPC_PGM_GO   = 8'h10;
  localparam logic [7:0] OPC_ERS_SET  = 8'h60;
  localparam logic [7:0] OPC_ERS_GO   = 8'hD0;
  localparam logic [7:0] OPC_STATUS   = 8'h70;

  typedef enum logic [2:0] {
    OP_READ, OP_IDENT, OP_RESET, OP_PSETUP,
    OP_PCOMMIT, OP_ESETUP, OP_ECOMMIT, OP_STATUS
  } op_e;

  typedef enum logic [1:0] {OFS_ZERO, OFS_HALF, OFS_SPARE} ofs_e;

  typedef enum logic [1:0] {SRC_NONE, SRC_IDENT, SRC_STAT, SRC_ARRAY} src_e;

  typedef struct packed {
    logic known;
    op_e  op;
    ofs_e ofs;
  } dec_t;

endpackage

// File: rtl/nand_op_decode.sv
module nand_op_decode
  import nand_fe_pkg::*;
(
  input  logic [7:0] opcode_i,
  output dec_t       dec_o
);

  always_comb begin
    dec_o.known = 1'b1;
    dec_o.op    = OP_READ;
    dec_o.ofs   = OFS_ZERO;
    unique case (opcode_i)
      OPC_RD_MAIN:  dec_o.ofs = OFS_ZERO;
      OPC_RD_HALF:  dec_o.ofs = OFS_HALF;
      OPC_RD_SPARE: dec_o.ofs = OFS_SPARE;
      OPC_IDENT:    dec_o.op  = OP_IDENT;
      OPC_RESET:    dec_o.op  = OP_RESET;
      OPC_PGM_SET:  dec_o.op  = OP_PSETUP;
      OPC_PGM_GO:   dec_o.op  = OP_PCOMMIT;
      OPC_ERS_SET:  dec_o.op  = OP_ESETUP;
      OPC_ERS_GO:   dec_o.op  = OP_ECOMMIT;
      OPC_STATUS:   dec_o.op  = OP_STATUS;
      default:      dec_o.known = 1'b0;
    endcase
  end

endmodule

// File: rtl/nand_addr_acc.sv
module nand_addr_acc #(
  parameter int ADDR_BYTES = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr_i,
  input  logic                    ld_i,
  input  logic [8*ADDR_BYTES-1:0] ld_val_i,
  input  logic                    wr_i,
  input  logic [7:0]              byte_i,
  output logic [7:0]              col_byte_o,
  output logic [8*ADDR_BYTES-9:0] row_next_o,
  output logic [8*ADDR_BYTES-1:0] masked_o,
  output logic [$clog2(ADDR_BYTES+1)-1:0] cnt_o
);

  localparam int ADDR_W = 8 * ADDR_BYTES;
  localparam int CNT_W  = $clog2(ADDR_BYTES + 1);

  logic [ADDR_W-1:0] addr_q, addr_d, addr_wr_val;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  always_comb begin
    addr_wr_val = addr_q;
    for (int i = 0; i < ADDR_BYTES; i++) begin
      if (cnt_q == CNT_W'(i)) addr_wr_val[i*8 +: 8] = byte_i;
    end
  end

  always_comb begin
    for (int i = 0; i < ADDR_BYTES; i++) begin
      masked_o[i*8 +: 8] = (CNT_W'(i) < cnt_q) ? addr_q[i*8 +: 8] : 8'h00;
    end
  end

  always_comb begin
    addr_d = addr_q;
    cnt_d  = cnt_q;
    if (ld_i) addr_d = ld_val_i;
    if (clr_i) begin
      cnt_d = '0;
    end else if (wr_i) begin
      addr_d = addr_wr_val;
      if (cnt_q != CNT_W'(ADDR_BYTES)) cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      addr_q <= addr_d;
      cnt_q  <= cnt_d;
    end
  end

  assign col_byte_o = addr_q[7:0];
  assign row_next_o = addr_wr_val[ADDR_W-1:8];
  assign cnt_o      = cnt_q;

  // R4
  byte_count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_i && !clr_i && cnt_q < CNT_W'(ADDR_BYTES)) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));

endmodule

// File: rtl/nand_resp_unit.sv
module nand_resp_unit
  import nand_fe_pkg::*;
#(
  parameter int         LEN_W     = 10,
  parameter logic [7:0] MFR_CODE  = 8'h3A,
  parameter logic [7:0] DEV_CODE  = 8'h73,
  parameter logic [7:0] FILL_CODE = 8'hA5,
  parameter logic [7:0] TAIL_CODE = 8'hC0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             ld_stat_i,
  input  logic [7:0]       stat_i,
  input  logic             ld_id_i,
  input  logic             ld_arr_i,
  input  logic [LEN_W-1:0] arr_len_i,
  input  logic             sel_n_i,
  input  logic             rd_i,
  input  logic [7:0]       arr_data_i,
  output logic [7:0]       io_o,
  output logic             arr_next_o
);

  src_e             src_q, src_d;
  logic [LEN_W-1:0] len_q, len_d;
  logic [1:0]       idx_q, idx_d;
  logic [7:0]       snap_q, snap_d;
  logic             active, adv, any_ld;

  assign active = !sel_n_i && (len_q != '0);
  assign adv    = rd_i && active;
  assign any_ld = clr_i || ld_stat_i || ld_id_i || ld_arr_i;

  always_comb begin
    io_o = 8'h00;
    if (active) begin
      unique case (src_q)
        SRC_IDENT: begin
          unique case (idx_q)
            2'd0: io_o = MFR_CODE;
            2'd1: io_o = DEV_CODE;
            2'd2: io_o = FILL_CODE;
            default: io_o = TAIL_CODE;
          endcase
        end
        SRC_STAT:  io_o = snap_q;
        SRC_ARRAY: io_o = arr_data_i;
        default:   io_o = 8'h00;
      endcase
    end
  end

  assign arr_next_o = adv && (src_q == SRC_ARRAY);

  always_comb begin
    src_d  = src_q;
    len_d  = len_q;
    idx_d  = idx_q;
    snap_d = snap_q;
    if (clr_i) begin
      src_d = SRC_NONE;
      len_d = '0;
      idx_d = '0;
    end else if (ld_stat_i) begin
      src_d  = SRC_STAT;
      len_d  = LEN_W'(1);
      snap_d = stat_i;
    end else if (ld_id_i) begin
      src_d = SRC_IDENT;
      len_d = LEN_W'(4);
      idx_d = '0;
    end else if (ld_arr_i) begin
      src_d = SRC_ARRAY;
      len_d = arr_len_i;
    end else if (adv && src_q != SRC_STAT) begin
      len_d = len_q - LEN_W'(1);
      idx_d = idx_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q  <= SRC_NONE;
      len_q  <= '0;
      idx_q  <= '0;
      snap_q <= '0;
    end else begin
      src_q  <= src_d;
      len_q  <= len_d;
      idx_q  <= idx_d;
      snap_q <= snap_d;
    end
  end

  // R7
  stat_repeat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_q == SRC_STAT && rd_i && !any_ld) |=> ($stable(len_q) && $stable(snap_q)));

  // R6
  ident_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_id_i && !clr_i && !ld_stat_i) |=> (len_q == LEN_W'(4) && idx_q == 2'd0));

endmodule

// File: rtl/nand_front_end.sv
module nand_front_end
  import nand_fe_pkg::*;
#(
  parameter int         PAGE_BYTES = 512,
  parameter int         ROW_BYTES  = 2,
  parameter logic [7:0] MFR_CODE   = 8'h3A,
  parameter logic [7:0] DEV_CODE   = 8'h73,
  parameter logic [7:0] FILL_CODE  = 8'hA5,
  parameter logic [7:0] TAIL_CODE  = 8'hC0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        chip_sel_n,
  input  logic        cmd_lat,
  input  logic        adr_lat,
  input  logic        wr_prot_n,
  input  logic        wr_stb,
  input  logic        rd_stb,
  input  logic [7:0]  io_in,
  output logic [7:0]  io_out,
  input  logic [7:0]  arr_rdata,
  output logic        arr_next,
  output logic        rd_start,
  output logic        pgm_open,
  output logic        pgm_data_we,
  output logic        pgm_commit,
  output logic        ers_start,
  output logic [$clog2(2*PAGE_BYTES)-1:0] op_col,
  output logic [8*ROW_BYTES-1:0]          op_row,
  output logic        bad_cmd
);

  localparam int SPARE_BYTES = PAGE_BYTES / 32;
  localparam int TOTAL       = PAGE_BYTES + SPARE_BYTES;
  localparam int ADDR_BYTES  = ROW_BYTES + 1;
  localparam int ADDR_W      = 8 * ADDR_BYTES;
  localparam int ROW_W       = 8 * ROW_BYTES;
  localparam int CNT_W       = $clog2(ADDR_BYTES + 1);
  localparam int LEN_W       = $clog2(TOTAL + 1);
  localparam int COL_W       = $clog2(2 * PAGE_BYTES);
  localparam int HALF_OFF    = PAGE_BYTES / 2;

  // reset: asynchronous assertion, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_n_int;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_int = rst_pipe[1];

  // strobe qualification
  logic cmd_wr, adr_wr, dat_wr;
  assign cmd_wr = wr_stb && !chip_sel_n && cmd_lat;
  assign adr_wr = wr_stb && !chip_sel_n && adr_lat && !cmd_lat;
  assign dat_wr = wr_stb && !chip_sel_n && !cmd_lat && !adr_lat;

  dec_t dec;
  nand_op_decode u_dec (
    .opcode_i (io_in),
    .dec_o    (dec)
  );

  // address accumulator
  logic              a_clr, a_ld;
  logic [ADDR_W-1:0] a_ldval, a_masked;
  logic [7:0]        a_col;
  logic [ROW_W-1:0]  a_row_next;
  logic [CNT_W-1:0]  a_cnt;

  nand_addr_acc #(.ADDR_BYTES(ADDR_BYTES)) u_addr (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .clr_i      (a_clr),
    .ld_i       (a_ld),
    .ld_val_i   (a_ldval),
    .wr_i       (adr_wr),
    .byte_i     (io_in),
    .col_byte_o (a_col),
    .row_next_o (a_row_next),
    .masked_o   (a_masked),
    .cnt_o      (a_cnt)
  );

  // control state
  op_e              cmd_q, cmd_d;
  logic [COL_W-1:0] off_q, off_d;
  logic [COL_W-1:0] col_q, col_d;
  logic [ROW_W-1:0] row_q, row_d;
  logic [LEN_W-1:0] pbytes_q, pbytes_d;
  logic             wp_q;
  logic             rd_q, rd_d, po_q, po_d, pc_q, pc_d, er_q, er_d, bad_q, bad_d;

  logic             r_clr, r_stat, r_id, r_arr;
  logic [COL_W-1:0] col_calc;
  logic [LEN_W-1:0] arr_len;
  logic             third_byte, pgm_room;
  logic [7:0]       status_byte;

  assign col_calc    = COL_W'(a_col) + off_q;
  assign arr_len     = (col_calc < COL_W'(TOTAL)) ? (LEN_W'(TOTAL) - LEN_W'(col_calc)) : '0;
  assign third_byte  = adr_wr && (a_cnt == CNT_W'(ADDR_BYTES - 1));
  assign pgm_room    = pbytes_q < LEN_W'(TOTAL);
  assign status_byte = {wp_q, 1'b1, 6'b000000};
  assign pgm_data_we = dat_wr && (cmd_q == OP_PSETUP) && pgm_room;

  always_comb begin
    cmd_d    = cmd_q;
    off_d    = off_q;
    col_d    = col_q;
    row_d    = row_q;
    pbytes_d = pbytes_q;
    rd_d     = 1'b0;
    po_d     = 1'b0;
    pc_d     = 1'b0;
    er_d     = 1'b0;
    bad_d    = 1'b0;
    a_clr    = 1'b0;
    a_ld     = 1'b0;
    a_ldval  = '0;
    r_clr    = 1'b0;
    r_stat   = 1'b0;
    r_id     = 1'b0;
    r_arr    = 1'b0;
    if (cmd_wr) begin
      if (!dec.known) begin
        bad_d = 1'b1;
      end else begin
        cmd_d = dec.op;
        a_clr = 1'b1;
        r_clr = (dec.op != OP_STATUS);
        unique case (dec.op)
          OP_READ: begin
            unique case (dec.ofs)
              OFS_HALF:  off_d = COL_W'(HALF_OFF);
              OFS_SPARE: off_d = COL_W'(PAGE_BYTES);
              default:   off_d = '0;
            endcase
          end
          OP_RESET: begin
            cmd_d = OP_READ;
            off_d = '0;
            a_ld  = 1'b1;
          end
          OP_PSETUP:  pbytes_d = '0;
          OP_PCOMMIT: pc_d = wr_prot_n;
          OP_ECOMMIT: begin
            a_ld    = 1'b1;
            a_ldval = ADDR_W'({a_masked, 8'h00});
            er_d    = wr_prot_n;
            if (wr_prot_n) row_d = a_masked[ROW_W-1:0];
          end
          OP_STATUS: r_stat = 1'b1;
          default: ;
        endcase
      end
    end else if (adr_wr) begin
      if (cmd_q == OP_IDENT && a_cnt == '0) r_id = 1'b1;
      if (third_byte && (cmd_q == OP_READ || cmd_q == OP_PSETUP)) begin
        col_d = col_calc;
        row_d = a_row_next;
        off_d = '0;
        if (cmd_q == OP_READ) begin
          rd_d  = 1'b1;
          r_arr = 1'b1;
        end else begin
          po_d = 1'b1;
        end
      end
    end else if (pgm_data_we) begin
      pbytes_d = pbytes_q + LEN_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n_int) begin
    if (!rst_n_int) begin
      cmd_q    <= OP_READ;
      off_q    <= '0;
      col_q    <= '0;
      row_q    <= '0;
      pbytes_q <= '0;
      wp_q     <= 1'b0;
      rd_q     <= 1'b0;
      po_q     <= 1'b0;
      pc_q     <= 1'b0;
      er_q     <= 1'b0;
      bad_q    <= 1'b0;
    end else begin
      cmd_q    <= cmd_d;
      off_q    <= off_d;
      col_q    <= col_d;
      row_q    <= row_d;
      pbytes_q <= pbytes_d;
      wp_q     <= wr_prot_n;
      rd_q     <= rd_d;
      po_q     <= po_d;
      pc_q     <= pc_d;
      er_q     <= er_d;
      bad_q    <= bad_d;
    end
  end

  nand_resp_unit #(
    .LEN_W     (LEN_W),
    .MFR_CODE  (MFR_CODE),
    .DEV_CODE  (DEV_CODE),
    .FILL_CODE (FILL_CODE),
    .TAIL_CODE (TAIL_CODE)
  ) u_resp (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .clr_i      (r_clr),
    .ld_stat_i  (r_stat),
    .stat_i     (status_byte),
    .ld_id_i    (r_id),
    .ld_arr_i   (r_arr),
    .arr_len_i  (arr_len),
    .sel_n_i    (chip_sel_n),
    .rd_i       (rd_stb),
    .arr_data_i (arr_rdata),
    .io_o       (io_out),
    .arr_next_o (arr_next)
  );

  assign rd_start   = rd_q;
  assign pgm_open   = po_q;
  assign pgm_commit = pc_q;
  assign ers_start  = er_q;
  assign bad_cmd    = bad_q;
  assign op_col     = col_q;
  assign op_row     = row_q;

  // R8
  commit_wp_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    pc_q |-> $past(wr_prot_n));

  // R9
  erase_wp_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    er_q |-> $past(wr_prot_n));

  // R5
  read_at_third_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    rd_q |-> (a_cnt == CNT_W'(ADDR_BYTES)));

  // R2
  bad_op_inert_chk: assert property (@(posedge clk) disable iff (!rst_n_int)
    (cmd_wr && !dec.known) |=> ($stable(cmd_q) && $stable(off_q) && $stable(a_cnt)));

endmodule

// File: tb/sim_nand_front_end.sv
module sim_nand_front_end;

  localparam int CLK_PERIOD = 10;
  localparam int TOTAL      = 528;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        chip_sel_n, cmd_lat, adr_lat, wr_prot_n, wr_stb, rd_stb;
  logic [7:0]  io_in, io_out, arr_rdata;
  logic        arr_next, rd_start, pgm_open, pgm_data_we, pgm_commit, ers_start, bad_cmd;
  logic [9:0]  op_col;
  logic [15:0] op_row;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  nand_front_end u0 (
    .clk(clk), .rst_n(rst_n), .chip_sel_n(chip_sel_n), .cmd_lat(cmd_lat),
    .adr_lat(adr_lat), .wr_prot_n(wr_prot_n), .wr_stb(wr_stb), .rd_stb(rd_stb),
    .io_in(io_in), .io_out(io_out), .arr_rdata(arr_rdata), .arr_next(arr_next),
    .rd_start(rd_start), .pgm_open(pgm_open), .pgm_data_we(pgm_data_we),
    .pgm_commit(pgm_commit), .ers_start(ers_start), .op_col(op_col),
    .op_row(op_row), .bad_cmd(bad_cmd)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_cmd(input logic [7:0] b);
    @(negedge clk);
    cmd_lat = 1'b1; io_in = b; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0; cmd_lat = 1'b0;
  endtask

  task automatic send_adr(input logic [7:0] b);
    @(negedge clk);
    adr_lat = 1'b1; io_in = b; wr_stb = 1'b1;
    @(negedge clk);
    wr_stb = 1'b0; adr_lat = 1'b0;
  endtask

  task automatic send_dat(input logic [7:0] b, output logic we);
    @(negedge clk);
    io_in = b; wr_stb = 1'b1;
    #1 we = pgm_data_we;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  task automatic read_byte(output logic [7:0] v, output logic nxt);
    @(negedge clk);
    v = io_out; rd_stb = 1'b1;
    #1 nxt = arr_next;
    @(negedge clk);
    rd_stb = 1'b0;
  endtask

  task automatic count_reads(input string req, output int cnt);
    logic [7:0] v;
    logic       nx;
    bit         ok = 1'b1;
    cnt = 0;
    while (io_out != 8'h00 && cnt < 600) begin
      read_byte(v, nx);
      if (v !== arr_rdata || nx !== 1'b1) ok = 1'b0;
      cnt++;
    end
    chk({req, " array bytes and arr_next"}, 32'(ok), 32'd1);
  endtask

  task automatic send_row3(input logic [7:0] a0, input logic [7:0] a1, input logic [7:0] a2);
    send_adr(a0); send_adr(a1); send_adr(a2);
  endtask

  task automatic t_reset_state;
    chk("R11 idle output after reset", io_out, 8'h00);
    chk("R5 no read pulse after reset", rd_start, 1'b0);
  endtask

  task automatic t_status;
    logic [7:0] v; logic nx;
    send_cmd(8'h70);
    chk("R7 status byte wp high", io_out, 8'hC0);
    read_byte(v, nx); read_byte(v, nx);
    chk("R7 status repeats", io_out, 8'hC0);
    wr_prot_n = 1'b0; idle(2);
    chk("R7 status latched at command", io_out, 8'hC0);
    send_cmd(8'h70);
    chk("R7 status byte wp low", io_out, 8'h40);
    wr_prot_n = 1'b1; idle(2);
  endtask

  task automatic t_ident;
    logic [7:0] v; logic nx;
    send_cmd(8'h90);
    chk("R6 nothing before address", io_out, 8'h00);
    send_adr(8'h00);
    read_byte(v, nx); chk("R6 id byte 0", v, 8'h3A);
    read_byte(v, nx); chk("R6 id byte 1", v, 8'h73);
    read_byte(v, nx); chk("R6 id byte 2", v, 8'hA5);
    read_byte(v, nx); chk("R6 id byte 3", v, 8'hC0);
    chk("R6 zero after id", io_out, 8'h00);
  endtask

  task automatic t_read_main;
    int n;
    send_cmd(8'h00);
    send_adr(8'h20); chk("R5 no start after byte 0", rd_start, 1'b0);
    send_adr(8'h34); chk("R5 no start after byte 1", rd_start, 1'b0);
    send_adr(8'h12);
    chk("R5 start at third byte", rd_start, 1'b1);
    chk("R5 column", op_col, 10'h020);
    chk("R4 row packing", op_row, 16'h1234);
    idle(1);
    chk("R5 start is one cycle", rd_start, 1'b0);
    count_reads("R5 main read", n);
    chk("R5 main read length", n, TOTAL - 32'h20);
  endtask

  task automatic t_read_offsets;
    int n;
    send_cmd(8'h01); send_row3(8'h10, 8'h00, 8'h00);
    chk("R3 half-page offset", op_col, 10'h110);
    count_reads("R3 half read", n);
    chk("R3 half read length", n, TOTAL - 32'h110);
    send_cmd(8'h00); send_row3(8'h10, 8'h00, 8'h00);
    chk("R3 offset cleared by 0x00", op_col, 10'h010);
    send_cmd(8'h50); send_row3(8'h05, 8'h07, 8'h00);
    chk("R3 spare offset", op_col, 10'h205);
    chk("R5 row spare read", op_row, 16'h0007);
    count_reads("R5 spare read", n);
    chk("R5 spare read length", n, 11);
    send_cmd(8'h50); send_row3(8'h20, 8'h00, 8'h00);
    chk("R5 past-end read start", rd_start, 1'b1);
    chk("R5 past-end read yields nothing", io_out, 8'h00);
  endtask

  task automatic t_reset_cmd;
    send_cmd(8'h50);
    send_cmd(8'hFF);
    chk("R10 no data after reset cmd", io_out, 8'h00);
    send_row3(8'h08, 8'h01, 8'h00);
    chk("R10 read mode after reset cmd", rd_start, 1'b1);
    chk("R10 offset cleared", op_col, 10'h008);
    send_cmd(8'h70);
    chk("R10 ready after reset cmd", io_out, 8'hC0);
  endtask

  task automatic t_addr_extra;
    send_cmd(8'h00); send_row3(8'h11, 8'h22, 8'h33);
    chk("R4 row bytes 1 and 2", op_row, 16'h3322);
    send_adr(8'h44);
    chk("R4 fourth byte ignored", rd_start, 1'b0);
    send_cmd(8'h60); send_adr(8'hAA); send_cmd(8'hD0);
    chk("R9 erase pulse single byte", ers_start, 1'b1);
    chk("R9 erase row masked to count", op_row, 16'h00AA);
  endtask

  task automatic t_program;
    logic we;
    bit   all_we = 1'b1;
    send_cmd(8'h80); send_row3(8'h00, 8'h09, 8'h00);
    chk("R8 program window pulse", pgm_open, 1'b1);
    chk("R8 program row", op_row, 16'h0009);
    chk("R8 program column", op_col, 10'h000);
    chk("R8 no read pulse in program", rd_start, 1'b0);
    for (int i = 0; i < TOTAL; i++) begin
      send_dat(8'(i), we);
      if (we !== 1'b1) all_we = 1'b0;
    end
    chk("R8 data enables for full page", 32'(all_we), 32'd1);
    send_dat(8'h55, we);
    chk("R8 data beyond page refused", we, 1'b0);
    send_cmd(8'h10);
    chk("R8 commit with wp high", pgm_commit, 1'b1);
    send_cmd(8'h80); send_row3(8'h00, 8'h0A, 8'h00);
    wr_prot_n = 1'b0;
    send_cmd(8'h10);
    chk("R8 commit blocked by wp", pgm_commit, 1'b0);
    wr_prot_n = 1'b1; idle(2);
  endtask

  task automatic t_erase;
    send_cmd(8'h60); send_adr(8'h78); send_adr(8'h56); send_cmd(8'hD0);
    chk("R9 erase pulse", ers_start, 1'b1);
    chk("R9 erase row", op_row, 16'h5678);
    idle(1);
    chk("R9 erase pulse one cycle", ers_start, 1'b0);
    send_cmd(8'h60); send_adr(8'h01); send_adr(8'h02);
    wr_prot_n = 1'b0;
    send_cmd(8'hD0);
    chk("R9 erase blocked by wp", ers_start, 1'b0);
    chk("R9 row kept when blocked", op_row, 16'h5678);
    wr_prot_n = 1'b1; idle(2);
  endtask

  task automatic t_unknown;
    send_cmd(8'h00); send_adr(8'h01); send_adr(8'h02);
    send_cmd(8'h33);
    chk("R2 unknown opcode flagged", bad_cmd, 1'b1);
    send_adr(8'h03);
    chk("R2 unknown opcode keeps count", rd_start, 1'b1);
    chk("R2 unknown opcode keeps row", op_row, 16'h0302);
    chk("R2 no flag on known opcode", bad_cmd, 1'b0);
  endtask

  task automatic t_chip_select;
    logic [7:0] v; logic nx;
    send_cmd(8'h90); send_adr(8'h00);
    chk("R11 id visible", io_out, 8'h3A);
    chip_sel_n = 1'b1; idle(1);
    chk("R11 zero when deselected", io_out, 8'h00);
    read_byte(v, nx);
    chip_sel_n = 1'b0; idle(1);
    chk("R11 deselected read does not advance", io_out, 8'h3A);
    send_cmd(8'h00);
    chk("R11 new command discards response", io_out, 8'h00);
    chip_sel_n = 1'b1;
    send_cmd(8'h70);
    send_cmd(8'h33);
    chk("R1 deselected opcode not flagged", bad_cmd, 1'b0);
    chip_sel_n = 1'b0; idle(1);
    chk("R1 deselected status command ignored", io_out, 8'h00);
    send_adr(8'h01); send_adr(8'h02);
    cmd_lat = 1'b1; adr_lat = 1'b1;
    send_adr(8'h03);
    cmd_lat = 1'b0;
    chk("R1 address needs cmd_lat low", rd_start, 1'b0);
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; chip_sel_n = 1'b0; cmd_lat = 1'b0; adr_lat = 1'b0;
    wr_prot_n = 1'b1; wr_stb = 1'b0; rd_stb = 1'b0; io_in = 8'h00;
    arr_rdata = 8'hB7;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    t_reset_state();
    t_status();
    t_ident();
    t_read_main();
    t_read_offsets();
    t_reset_cmd();
    t_addr_extra();
    t_program();
    t_erase();
    t_unknown();
    t_chip_select();
    done = 1'b1;
    report();
    $finish;
  end

endmodule